// File: doc/BRIEF.md
# Multi-Position Shift Unit

This block shifts or rotates one register-width operand by one to four bit positions. The operand can be treated as either 16 or 20 bits wide. Every shift passes through the carry flag. The unit returns the shifted value, the final carry, and negative and zero flags for that value. Right shifts come in three kinds: through carry, unsigned and sign-keeping. The unit also has an arithmetic left shift and a single-position rotate left through carry.

The datapath works one position per clock. A `start` pulse while the unit is idle captures the operand, the count, the mode, the width and the carry-in, and it also performs the first step on that same edge. Each further step takes one edge. `done` is high for one cycle after the last step. The result and the flags then stay stable until the next accepted start. A start that arrives while the unit is busy is dropped.

In 16-bit mode, operand bits 19:16 are ignored and result bits 19:16 are forced to zero. The sign bit, and the bit that feeds or leaves the top of the word, is bit 15 in 16-bit mode and bit 19 in 20-bit mode.

Top module: `shf_unit`

## Requirements
- R1: `cnt_m1` encodes the shift count minus one, so codes 0 to 3 select 1, 2, 3 or 4 positions. The result equals that many successive single-position steps of the selected mode.
- R2: When `wide` is 0, result bits 19:16 are zero, operand bits 19:16 have no effect, and bit 15 acts as the MSB.
- R3: Mode code 0 (rotate right through carry): at each step the carry enters the MSB and the bit leaving bit 0 becomes the new carry.
- R4: Mode code 1 (unsigned shift right): at each step zero enters the MSB and bit 0 goes to carry.
- R5: Mode code 2 (arithmetic shift right): at each step the MSB keeps its value and bit 0 goes to carry.
- R6: Mode code 3 (arithmetic shift left): at each step zero enters bit 0 and the bit leaving the MSB goes to carry.
- R7: Mode codes 4 to 7 (rotate left through carry) always make exactly one step, whatever `cnt_m1` holds. The carry enters bit 0 and the MSB goes to carry.
- R8: `neg` equals the MSB of the result at the selected width, and `zero` is 1 exactly when the result is zero.
- R9: For a count of n, `done` is high in the cycle after the n-th rising edge, counting the edge that accepts `start` as the first. `done` is high for one cycle. `busy` is high in the cycles in between.
- R10: A `start` while `busy` is high produces no extra `done` and does not disturb the operation in progress.
- R11: After reset, `busy` and `done` are 0, `result` and `carry_out` are 0, `zero` is 1 and `neg` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when not busy) |
| operand | input | 20 | Value to shift |
| cnt_m1 | input | 2 | Shift count minus one |
| mode | input | 3 | Operation code (0..3 as R3-R6 list, 4..7 rotate left) |
| wide | input | 1 | 1 = 20-bit operation, 0 = 16-bit |
| carry_in | input | 1 | Initial carry |
| busy | output | 1 | Operation in progress, more steps pending |
| done | output | 1 | One-cycle completion pulse |
| result | output | 20 | Shifted value |
| carry_out | output | 1 | Final carry |
| neg | output | 1 | Sign of result at selected width |
| zero | output | 1 | Result is zero |

## Verification
A step counter that is off by one makes `done` appear one cycle early or late. The result then also differs from the expected n-step value by one position, so the scoreboard catches both on the same completion pulse. A latched width or mode that is wrong turns up in the first result, because upper bits are left nonzero or the wrong bit is fed into the MSB. A carry register that is not updated between steps corrupts the result only for counts of two or more, so every mode is exercised with all four counts and both widths.

// File: rtl/shf_pkg.sv
// Shared types for the shift unit.
// Assumes: mode codes 4..7 all select the single-step rotate left.
package shf_pkg;
    typedef enum logic [2:0] {
        SHF_RRC = 3'd0,   // rotate right through carry
        SHF_SRL = 3'd1,   // unsigned shift right
        SHF_SRA = 3'd2,   // sign-keeping shift right
        SHF_SLA = 3'd3,   // arithmetic shift left
        SHF_RLC = 3'd4    // rotate left through carry, one step
    } shf_mode_e;

    // Map a raw 3-bit code onto the supported operations.
    function automatic shf_mode_e shf_decode(input logic [2:0] code);
        return code[2] ? SHF_RLC : shf_mode_e'(code);
    endfunction
endpackage

// File: rtl/shf_step.sv
// One-position shift step, purely combinational.
// Assumes: in narrow mode the bits of x above NARROW_W-1 are already zero.
module shf_step
    import shf_pkg::*;
#(
    parameter int DATA_W   = 20,
    parameter int NARROW_W = 16
) (
    input  logic [DATA_W-1:0] x,
    input  logic              cin,
    input  shf_mode_e         mode,
    input  logic              wide,
    output logic [DATA_W-1:0] y,
    output logic              cout
);
    localparam int UPPER_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] top_onehot;
    logic              msb_bit;
    logic              fill_bit;
    logic [DATA_W-1:0] shr;
    logic [DATA_W-1:0] shl;

    // Select width mask and position of the working MSB.
    always_comb begin
        width_mask = wide ? {DATA_W{1'b1}} : {{UPPER_W{1'b0}}, {NARROW_W{1'b1}}};
        top_onehot = wide ? ({{(DATA_W-1){1'b0}}, 1'b1} << (DATA_W-1))
                          : ({{(DATA_W-1){1'b0}}, 1'b1} << (NARROW_W-1));
        msb_bit    = |(x & top_onehot);
    end

    // Bit entering the MSB on right shifts.
    always_comb begin
        unique case (mode)
            SHF_RRC: fill_bit = cin;
            SHF_SRA: fill_bit = msb_bit;
            default: fill_bit = 1'b0;
        endcase
    end

    // Per-bit right shift: each bit takes its upper neighbour, the top takes the fill.
    for (genvar i = 0; i < DATA_W; i++) begin : g_shr
        if (i == DATA_W-1) begin : g_top
            assign shr[i] = top_onehot[i] ? fill_bit : 1'b0;
        end else begin : g_mid
            assign shr[i] = top_onehot[i] ? fill_bit : (x[i+1] & width_mask[i]);
        end
    end

    // Left shift with the rotate-in bit at position zero.
    always_comb shl = {x[DATA_W-2:0], (mode == SHF_RLC) ? cin : 1'b0} & width_mask;

    // Pick direction and the outgoing carry.
    always_comb begin
        if (mode == SHF_SLA || mode == SHF_RLC) begin
            y    = shl;
            cout = msb_bit;
        end else begin
            y    = shr;
            cout = x[0];
        end
    end
endmodule

// File: rtl/shf_seq.sv
// Step sequencer: counts the remaining steps and produces busy and done.
// Assumes: the first step is taken on the accepting edge itself.
module shf_seq #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt_m1,
    input  logic             single,
    output logic             accept,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] first_rem;

    // A new operation is taken only when idle.
    always_comb accept = start && !busy;
    // Steps still to do after the accepting edge.
    always_comb first_rem = single ? '0 : cnt_m1;

    // Advance the step count, raise done after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else if (accept) begin
            remain_q <= first_rem;
            busy     <= (first_rem != '0);
            done     <= (first_rem == '0);
        end else if (busy) begin
            remain_q <= remain_q - 1'b1;
            busy     <= (remain_q != 1);
            done     <= (remain_q == 1);
        end else begin
            done     <= 1'b0;
        end
    end

    // R9: busy and done never overlap
    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R9: a busy operation either continues or completes
    a_r9_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));
    // R10: a start during busy does not restart the count
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && remain_q == 1) |=> (done && !busy));
endmodule

// File: rtl/shf_flags.sv
// Negative and zero flags for the stored result.
// Assumes: bits above the narrow width are zero in narrow mode.
module shf_flags #(
    parameter int DATA_W   = 20,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] value,
    input  logic              wide,
    output logic              neg,
    output logic              zero
);
    // Sign from the width-selected MSB, zero from the whole value.
    always_comb begin
        neg  = wide ? value[DATA_W-1] : value[NARROW_W-1];
        zero = (value == '0);
    end

    // R8: a zero result is never flagged negative
    a_r8_zero_not_neg: assert property (@(posedge clk) disable iff (!rst_n)
        zero |-> !neg);
endmodule

// File: rtl/shf_unit.sv
// Top: iterative 16/20-bit shift unit, one position per clock.
// Assumes: result and flags are meaningful from the done pulse until the next start.
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W   = 20,
    parameter int NARROW_W = 16,
    parameter int CNT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  cnt_m1,
    input  logic [2:0]        mode,
    input  logic              wide,
    input  logic              carry_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              neg,
    output logic              zero
);
    localparam int UPPER_W = DATA_W - NARROW_W;

    shf_mode_e         mode_in;
    shf_mode_e         mode_q;
    logic              wide_q;
    logic [DATA_W-1:0] data_q;
    logic              carry_q;
    logic              accept;
    logic [DATA_W-1:0] src;
    logic              src_c;
    shf_mode_e         src_mode;
    logic              src_wide;
    logic [DATA_W-1:0] step_y;
    logic              step_c;

    // Decode the raw mode code.
    always_comb mode_in = shf_decode(mode);

    shf_seq #(.CNT_W(CNT_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .cnt_m1 (cnt_m1),
        .single (mode_in == SHF_RLC),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    // Step source: fresh inputs on accept, otherwise the held state.
    always_comb begin
        if (accept) begin
            src      = wide ? operand : {{UPPER_W{1'b0}}, operand[NARROW_W-1:0]};
            src_c    = carry_in;
            src_mode = mode_in;
            src_wide = wide;
        end else begin
            src      = data_q;
            src_c    = carry_q;
            src_mode = mode_q;
            src_wide = wide_q;
        end
    end

    shf_step #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_step (
        .x    (src),
        .cin  (src_c),
        .mode (src_mode),
        .wide (src_wide),
        .y    (step_y),
        .cout (step_c)
    );

    // Hold the working value, carry and operation setup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            carry_q <= 1'b0;
            mode_q  <= SHF_RRC;
            wide_q  <= 1'b0;
        end else if (accept || busy) begin
            data_q  <= step_y;
            carry_q <= step_c;
            mode_q  <= src_mode;
            wide_q  <= src_wide;
        end
    end

    shf_flags #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .value (data_q),
        .wide  (wide_q),
        .neg   (neg),
        .zero  (zero)
    );

    always_comb result    = data_q;
    always_comb carry_out = carry_q;

    // R2: narrow operations leave the upper bits clear
    a_r2_narrow_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_q |-> (data_q[DATA_W-1:NARROW_W] == '0));
    // R10: setup is held steady while busy
    a_r10_setup_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(wide_q) && $stable(mode_q)));
endmodule

// File: tb/sim_shf_unit.sv
module sim_shf_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] operand = '0;
    logic [1:0]  cnt_m1 = '0;
    logic [2:0]  mode = '0;
    logic        wide = 1'b0;
    logic        carry_in = 1'b0;
    logic        busy, done, carry_out, neg, zero;
    logic [19:0] result;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int dones = 0;
    int pushes = 0;
    bit finished = 0;

    typedef struct {
        logic [19:0] r;
        logic        c;
        logic        n;
        logic        z;
        int          due;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shf_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .cnt_m1(cnt_m1), .mode(mode), .wide(wide), .carry_in(carry_in),
        .busy(busy), .done(done), .result(result), .carry_out(carry_out),
        .neg(neg), .zero(zero)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Reference: step-by-step from the requirements.
    function automatic exp_t model(logic [19:0] op, int n, int md, logic wd, logic ci);
        exp_t e;
        int top = wd ? 19 : 15;
        logic [19:0] r = wd ? op : {4'b0, op[15:0]};
        logic c = ci;
        logic keep, nc;
        if (md >= 4) n = 1;
        for (int k = 0; k < n; k++) begin
            case (md)
                0: begin nc = r[0]; r = r >> 1; r[top] = c; c = nc; end
                1: begin c = r[0]; r = r >> 1; r[top] = 1'b0; end
                2: begin keep = r[top]; c = r[0]; r = r >> 1; r[top] = keep; end
                3: begin c = r[top]; r = r << 1; end
                default: begin nc = r[top]; r = (r << 1) | {19'b0, c}; c = nc; end
            endcase
            if (!wd) r[19:16] = 4'b0;
        end
        e.r = r; e.c = c; e.n = r[top]; e.z = (r == 20'b0);
        e.due = 0; e.req = "";
        return e;
    endfunction

    // Driver: issue one operation, push its expectation, wait for completion.
    task automatic run_op(input logic [19:0] op, input int n, input int md,
                          input logic wd, input logic ci, input string req);
        exp_t e;
        int neff;
        neff = (md >= 4) ? 1 : n;
        @(negedge clk);
        operand = op; cnt_m1 = 2'(n - 1); mode = 3'(md); wide = wd; carry_in = ci;
        start = 1'b1;
        e = model(op, n, md, wd, ci);
        e.due = cyc + neff;
        e.req = req;
        sb.push_back(e);
        pushes++;
        @(negedge clk);
        start = 1'b0;
        if (neff > 1) check(busy === 1'b1, "R9 busy after accept", {31'b0, busy}, 32'h1);
        for (int w = 0; w < 10 && sb.size() != 0; w++) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each completion against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done === 1'b1) begin
            exp_t e;
            dones++;
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected done", 32'h1, 32'h0);
            end else begin
                e = sb.pop_front();
                check(result === e.r, {e.req, " R1 result"}, {12'b0, result}, {12'b0, e.r});
                check(carry_out === e.c, {e.req, " carry"}, {31'b0, carry_out}, {31'b0, e.c});
                check(neg === e.n, "R8 neg", {31'b0, neg}, {31'b0, e.n});
                check(zero === e.z, "R8 zero", {31'b0, zero}, {31'b0, e.z});
                check(cyc == e.due, "R9 done cycle", cyc, e.due);
                check(busy === 1'b0, "R9 busy low at done", {31'b0, busy}, 32'h0);
            end
        end
    end

    initial begin
        logic [19:0] ops [4];
        string tags [5];
        ops[0] = 20'hA5C3F; ops[1] = 20'h81234; ops[2] = 20'hF8001; ops[3] = 20'h3C5A6;
        tags[0] = "R3"; tags[1] = "R4"; tags[2] = "R5"; tags[3] = "R6"; tags[4] = "R7";

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(busy === 1'b0 && done === 1'b0, "R11 busy/done", {30'b0, busy, done}, 32'h0);
        check(result === 20'h0 && carry_out === 1'b0, "R11 result/carry", {11'b0, carry_out, result}, 32'h0);
        check(zero === 1'b1 && neg === 1'b0, "R11 flags", {30'b0, zero, neg}, 32'h2);

        // Every mode, every count, both widths.
        for (int md = 0; md < 5; md++)
            for (int n = 1; n <= 4; n++)
                for (int wd = 0; wd < 2; wd++)
                    run_op(ops[(md + n + wd) % 4], n, md, wd[0], n[0], tags[md]);

        // R7: codes 5..7 and a large count still make one rotate-left step.
        run_op(20'h48001, 4, 7, 1'b1, 1'b1, "R7");
        run_op(20'h08001, 3, 5, 1'b0, 1'b0, "R7");
        // R2: upper operand bits ignored in narrow mode, result zero.
        run_op(20'hF0000, 2, 3, 1'b0, 1'b0, "R2");
        // R8: shift down to zero, carry picks up the last bit.
        run_op(20'h00001, 1, 1, 1'b1, 1'b0, "R8");
        // R5: narrow sign kept at bit 15.
        run_op(20'h08000, 4, 2, 1'b0, 1'b0, "R5");

        // R10: a second start while busy is dropped.
        @(negedge clk);
        operand = 20'h12345; cnt_m1 = 2'd3; mode = 3'd0; wide = 1'b1; carry_in = 1'b1;
        start = 1'b1;
        begin
            exp_t e;
            e = model(20'h12345, 4, 0, 1'b1, 1'b1);
            e.due = cyc + 4; e.req = "R10";
            sb.push_back(e); pushes++;
        end
        @(negedge clk);
        operand = 20'hFFFFF; cnt_m1 = 2'd0; mode = 3'd3; wide = 1'b0; carry_in = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        check(dones == pushes, "R10 done count", dones, pushes);
        check(sb.size() == 0, "R10 scoreboard drained", sb.size(), 0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R9 watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule